// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Detection

This block drives and senses a row of general-purpose pins and turns pin activity into a single interrupt request. Software reaches it over a plain 32-bit register bus with a byte address, a write strobe and a combinational read path. Every pin has an output latch, a direction bit and a readback of its input after a two-flop synchronizer.

Each pin also has a detector that watches the synchronized input. The detector can be set to fire on a rising edge, a falling edge, either edge, a high level or a low level. Detector hits land in a status register when the pin is enabled. A mask, set and cleared through separate write-one registers, decides which pending bits reach the interrupt output. A soft-reset register returns all registers to their power-up values when it is written with 1 and then with 0.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_out` and `pin_oe` are zero and `irq` is low.
- R2: The output latch (byte offset 0x18) drives `pin_out` and the direction register (0x20) drives `pin_oe`, where a 1 means output; enable (0x00), output, direction and use-select (0x38) are read/write, and bits at or above NPINS read as zero.
- R3: The input register (0x1C) shows each pin after two clock edges of synchronization: it still shows the old value one edge after a change and the new value after the second.
- R4: Each pin's detector mode is a 3-bit code in the low bits of a 4-bit nibble; pins 0..7 use the nibble at bits 4*i of mode register 0 (0x24) and pins 8 and up use the nibble at bits 4*(i-8) of mode register 1 (0x28); code 0 is falling edge, 1 rising edge, 2 low level, 3 high level, 4 either edge, and codes 5 to 7 never fire; nibble bit 3 reads as zero.
- R5: An edge event sets its status bit (0x04), which stays set until a 1 is written to that bit of the clear register (0x0C); writing 0 there leaves it set.
- R6: In a level mode the status bit is set again on every cycle the level persists, so a clear written while the level is active does not remove it.
- R7: A status bit is only set while that pin's enable bit is 1.
- R8: Writing 1 to a bit of mask-set (0x10) masks the pin, writing 1 to mask-clear (0x14) unmasks it, writing 0 to either has no effect; both offsets read back the mask.
- R9: `irq` is high exactly when some pin has status 1 and mask 0, and the display register (0x08) reads status with masked bits removed.
- R10: Writing 1 to bit 0 of the reset register (0x3C) changes nothing else; a following write of 0 returns every register to its reset value.
- R11: With the enable bit set, an input change made between clock edges reaches the status register and `irq` on the third rising edge after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Raw pin inputs |
| pin_out | output | NPINS | Output latch value |
| pin_oe | output | NPINS | Output enable per pin (direction) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default of 12 pins, so the second mode register and its nibble placement for pins 8 to 11 are exercised, as is the trimming of writes to the upper 20 bits of every register. Pins in both mode registers are driven through each detection code, including a reserved one, and the sampling points are set by the three-edge latency so that an off-by-one in the synchronizer shows up as a wrong status value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_ENA   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_DISP  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_MSET  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_MCLR  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_OUT   = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IN    = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_MODE0 = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_MODE1 = 6'h28;
  localparam logic [ADDR_W-1:0] OFS_USE   = 6'h38;
  localparam logic [ADDR_W-1:0] OFS_SRST  = 6'h3C;

  typedef enum logic [2:0] {
    DET_FALL = 3'd0,
    DET_RISE = 3'd1,
    DET_LOW  = 3'd2,
    DET_HIGH = 3'd3,
    DET_BOTH = 3'd4
  } det_mode_e;

  // Detector decision for one pin: current and previous synchronized value.
  function automatic logic det_hit(input logic [2:0] code, input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (code)
      DET_FALL: det_hit = fall;
      DET_RISE: det_hit = rise;
      DET_LOW:  det_hit = ~cur;
      DET_HIGH: det_hit = cur;
      DET_BOTH: det_hit = rise | fall;
      default:  det_hit = 1'b0;
    endcase
  endfunction

  // Nibble slot of a pin inside its mode register.
  function automatic int mode_slot(input int pin);
    mode_slot = 4 * (pin % 8);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
    end else begin
      meta_q <= raw;
      cur    <= meta_q;
      prev   <= cur;
    end
  end

  // R3: the delayed copy trails the synchronized value by exactly one edge
  p_prev_trails_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev == $past(cur)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect import gpio_irq_pkg::*; #(
  parameter int NPINS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      cur,
  input  logic [NPINS-1:0]      prev,
  input  logic [NPINS-1:0][2:0] mode,
  output logic [NPINS-1:0]      hit
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign hit[g] = det_hit(mode[g], cur[g], prev[g]);

    // R4: edge codes fire only when the input actually changed
    p_edge_needs_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && (mode[g] == DET_RISE || mode[g] == DET_FALL || mode[g] == DET_BOTH))
        |-> (cur[g] != prev[g]));

    // R4: reserved codes never fire
    p_reserved_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[g] > DET_BOTH) |-> !hit[g]);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl import gpio_irq_pkg::*; #(
  parameter int NPINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  localparam int LO_PINS = (NPINS < 8) ? NPINS : 8;

  logic [NPINS-1:0]      ena_q, stat_q, mask_q, out_q, dir_q, use_q;
  logic [NPINS-1:0][2:0] mode_q;
  logic                  arm_q;

  logic [NPINS-1:0] sync_cur, sync_prev, hit;
  logic [NPINS-1:0] wdat, clr_bits, pend;
  logic             wr_en, soft_clr;

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(sync_cur), .prev(sync_prev));

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .cur(sync_cur), .prev(sync_prev), .mode(mode_q), .hit(hit));

  assign wr_en    = bus_sel & bus_wr;
  assign wdat     = bus_wdata[NPINS-1:0];
  assign soft_clr = wr_en && (bus_addr == OFS_SRST) && !bus_wdata[0] && arm_q;
  assign clr_bits = (wr_en && bus_addr == OFS_CLR) ? wdat : '0;
  assign pend     = stat_q & ~mask_q;
  assign irq      = |pend;
  assign pin_out  = out_q;
  assign pin_oe   = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0; stat_q <= '0; mask_q <= '0; out_q <= '0;
      dir_q <= '0; use_q <= '0; mode_q <= '0; arm_q <= 1'b0;
    end else if (soft_clr) begin
      ena_q <= '0; stat_q <= '0; mask_q <= '0; out_q <= '0;
      dir_q <= '0; use_q <= '0; mode_q <= '0; arm_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | (hit & ena_q);
      if (wr_en) begin
        case (bus_addr)
          OFS_ENA:  ena_q  <= wdat;
          OFS_MSET: mask_q <= mask_q | wdat;
          OFS_MCLR: mask_q <= mask_q & ~wdat;
          OFS_OUT:  out_q  <= wdat;
          OFS_DIR:  dir_q  <= wdat;
          OFS_USE:  use_q  <= wdat;
          OFS_SRST: arm_q  <= bus_wdata[0];
          OFS_MODE0: begin
            for (int i = 0; i < LO_PINS; i++) mode_q[i] <= bus_wdata[mode_slot(i) +: 3];
          end
          OFS_MODE1: begin
            for (int i = 8; i < NPINS; i++) mode_q[i] <= bus_wdata[mode_slot(i) +: 3];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_ENA:  bus_rdata = 32'(ena_q);
      OFS_STAT: bus_rdata = 32'(stat_q);
      OFS_DISP: bus_rdata = 32'(pend);
      OFS_MSET, OFS_MCLR: bus_rdata = 32'(mask_q);
      OFS_OUT:  bus_rdata = 32'(out_q);
      OFS_IN:   bus_rdata = 32'(sync_cur);
      OFS_DIR:  bus_rdata = 32'(dir_q);
      OFS_USE:  bus_rdata = 32'(use_q);
      OFS_SRST: bus_rdata = {31'b0, arm_q};
      OFS_MODE0: for (int i = 0; i < LO_PINS; i++) bus_rdata[mode_slot(i) +: 3] = mode_q[i];
      OFS_MODE1: for (int i = 8; i < NPINS; i++) bus_rdata[mode_slot(i) +: 3] = mode_q[i];
      default: bus_rdata = '0;
    endcase
  end

  // R7: a status bit can only rise for a pin that was enabled
  p_status_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ena_q)) == '0));

  // R5: without a clear or soft reset, pending bits stay set
  p_status_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && bus_addr == OFS_CLR) && !soft_clr) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8: ones written to mask-set end up masked
  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFS_MSET) |=> ((mask_q & $past(wdat)) == $past(wdat)));

  // R8: zero bits of a mask-set write leave the mask alone
  p_mask_zero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFS_MSET) |=> ((mask_q & ~$past(wdat)) == ($past(mask_q) & ~$past(wdat))));

  // R10: the 1-then-0 sequence clears the control state
  p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (ena_q == '0 && mask_q == '0 && stat_q == '0 && dir_q == '0 && !arm_q));

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int NPINS = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_sel, bus_wr;
  logic [5:0]        bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [NPINS-1:0]  pin_in, pin_out, pin_oe;
  logic              irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(NPINS)) u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  // {offset, write value, expected readback}
  localparam logic [69:0] RW_TBL [7] = '{
    {6'h18, 32'hFFFF_FFFF, 32'h0000_0FFF},
    {6'h20, 32'h0000_0A5A, 32'h0000_0A5A},
    {6'h24, 32'hFFFF_FFFF, 32'h7777_7777},
    {6'h28, 32'hFFFF_FFFF, 32'h0000_7777},
    {6'h00, 32'h0001_FFFF, 32'h0000_0FFF},
    {6'h38, 32'h1234_5678, 32'h0000_0678},
    {6'h10, 32'h0000_00F0, 32'h0000_00F0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    expect_reg("R1 enable", 6'h00, 32'h0);
    expect_reg("R1 mode0", 6'h24, 32'h0);
    expect_reg("R1 mask", 6'h10, 32'h0);
    chk("R1 pin_oe", 32'(pin_oe), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R2 R4 R8 table of write/readback vectors
    for (int k = 0; k < 7; k++) begin
      wr(RW_TBL[k][69:64], RW_TBL[k][63:32]);
      expect_reg("R2/R4/R8 table", RW_TBL[k][69:64], RW_TBL[k][31:0]);
    end
    chk("R2 pin_oe", 32'(pin_oe), 32'h0000_0A5A);
    chk("R2 pin_out", 32'(pin_out), 32'h0000_0FFF);

    // setup: unmask, all pins mode set, clear any status
    wr(6'h14, 32'hFFFF_FFFF);
    expect_reg("R8 mask-clear", 6'h14, 32'h0);
    wr(6'h24, 32'h7777_7401);   // pin0 rise, pin1 fall, pin2 both
    wr(6'h28, 32'h0000_7737);   // pin9 level high
    expect_reg("R4 mode1 nibble", 6'h28, 32'h0000_7737);
    wr(6'h0C, 32'h0000_0FFF);
    expect_reg("R5 status clean", 6'h04, 32'h0);

    // R7 disabled pin does not latch
    wr(6'h00, 32'h0);
    @(negedge clk); pin_in[0] = 1'b1;
    step(4);
    expect_reg("R7 disabled", 6'h04, 32'h0);
    pin_in[0] = 1'b0;
    step(4);
    wr(6'h00, 32'h0000_0FFF);

    // R11 latency and R3 sync
    @(negedge clk); pin_in[0] = 1'b1;
    step(1);
    expect_reg("R3 input one edge", 6'h1C, 32'h0);
    step(1);
    expect_reg("R3 input two edges", 6'h1C, 32'h1);
    expect_reg("R11 status at second edge", 6'h04, 32'h0);
    step(1);
    expect_reg("R11 status at third edge", 6'h04, 32'h1);
    chk("R11 irq", 32'(irq), 32'h1);

    // R5 clear behaviour
    wr(6'h0C, 32'h0);
    expect_reg("R5 zero clear", 6'h04, 32'h1);
    wr(6'h0C, 32'h1);
    expect_reg("R5 one clear", 6'h04, 32'h0);
    chk("R9 irq low", 32'(irq), 32'h0);

    // R4 falling and both-edge codes
    @(negedge clk); pin_in[1] = 1'b1; pin_in[2] = 1'b1;
    step(4);
    expect_reg("R4 rise on fall pin / both pin", 6'h04, 32'h4);
    @(negedge clk); pin_in[1] = 1'b0; pin_in[2] = 1'b0;
    step(4);
    expect_reg("R4 fall and both", 6'h04, 32'h6);
    wr(6'h0C, 32'hFFF);

    // R6 level high on pin9
    @(negedge clk); pin_in[9] = 1'b1;
    step(4);
    expect_reg("R6 level set", 6'h04, 32'h200);
    wr(6'h0C, 32'h200);
    expect_reg("R6 level re-set", 6'h04, 32'h200);
    @(negedge clk); pin_in[9] = 1'b0;
    step(4);
    wr(6'h0C, 32'h200);
    expect_reg("R6 level gone", 6'h04, 32'h0);

    // R8 R9 mask and display
    pin_in[0] = 1'b0;
    step(4);
    @(negedge clk); pin_in[0] = 1'b1;
    step(4);
    wr(6'h10, 32'h1);
    expect_reg("R9 display masked", 6'h08, 32'h0);
    chk("R9 irq masked", 32'(irq), 32'h0);
    expect_reg("R9 status kept", 6'h04, 32'h1);
    wr(6'h14, 32'h0);
    expect_reg("R8 zero unmask", 6'h10, 32'h1);
    wr(6'h14, 32'h1);
    expect_reg("R9 display", 6'h08, 32'h1);
    chk("R9 irq", 32'(irq), 32'h1);
    wr(6'h0C, 32'hFFF);

    // R4 level low and reserved code
    wr(6'h24, 32'h7775_2401);
    step(1);
    expect_reg("R4 level low", 6'h04, 32'h8);
    @(negedge clk); pin_in[4] = 1'b1;
    step(4);
    pin_in[4] = 1'b0;
    step(4);
    expect_reg("R4 reserved code", 6'h04, 32'h8);

    // R10 soft reset
    wr(6'h3C, 32'h1);
    expect_reg("R10 arm only", 6'h00, 32'h0000_0FFF);
    expect_reg("R10 arm read", 6'h3C, 32'h1);
    wr(6'h3C, 32'h0);
    expect_reg("R10 enable", 6'h00, 32'h0);
    expect_reg("R10 mode0", 6'h24, 32'h0);
    expect_reg("R10 status", 6'h04, 32'h0);
    expect_reg("R10 use", 6'h38, 32'h0);
    chk("R10 pin_oe", 32'(pin_oe), 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule